// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits on the receive path of an Ethernet MAC and decides whether an incoming frame is kept. The receive logic presents the six destination-address bytes one per cycle, with a start strobe on the first byte. The filter compares the address against a programmed station address. It runs a CRC-32 over the address bytes, one byte per cycle, to index a 64-bin multicast hash table. It combines these results with a set of mode bits in a control word.

One cycle after the sixth address byte, the block gives a one-cycle decision strobe. It also gives an accept bit, a filter-fail bit, and multicast and broadcast flags that describe accepted frames. These outputs hold their values until the next decision. Any bytes that follow the address are ignored. The configuration inputs are treated as static register contents, sampled when the decision is formed.

Top module: `rx_addr_filter`

## Requirements
- R1: The station address is byte 0 in `sta_lo[7:0]`, byte 1 in `sta_lo[15:8]`, byte 2 in `sta_lo[23:16]`, byte 3 in `sta_lo[31:24]`, byte 4 in `sta_hi[7:0]` and byte 5 in `sta_hi[15:8]`, where byte 0 is the first byte received. A unicast frame whose six bytes equal the station address is accepted. With no mode bits set, any other unicast frame is rejected.
- R2: A destination of six 0xFF bytes is broadcast. It is accepted unless `ctrl[11]` is set, and it is never reported as multicast, even when bit 0 of its first byte is 1.
- R3: A non-broadcast destination whose first byte has bit 0 set is multicast. It is accepted when `ctrl[19]` is set, or when `ctrl[13]` is set and its hash bin is marked. Otherwise it is rejected.
- R4: The hash bin is bits 31:26 of a CRC-32 register. The register starts at all ones and takes the six address bytes in arrival order, each byte LSB first, with the reflected polynomial 0xEDB88320 and no final complement. Bins 0 to 31 are bits 0 to 31 of `hash_lo`, and bins 32 to 63 are bits 0 to 31 of `hash_hi`.
- R5: When `ctrl[13]` and `ctrl[15]` are both set, a unicast frame is accepted only on a hash-bin hit and the station address is not compared. With `ctrl[13]` alone, unicast still uses the exact station match.
- R6: `ctrl[18]` accepts every frame, and it takes precedence over every other mode bit, including the inverse bit.
- R7: When `ctrl[18]` is clear, `ctrl[17]` inverts the accept decision that the other modes produce.
- R8: At each decision, `filt_fail` is the complement of `accept`. `is_mcast` and `is_bcast` are set only for an accepted multicast or broadcast frame, respectively.
- R9: `dec_valid` pulses for exactly one cycle, in the cycle after the sixth address byte is taken. `accept`, `filt_fail`, `is_mcast` and `is_bcast` are updated only with that pulse and otherwise hold.
- R10: Bytes after the sixth are ignored until the next `sof`. A byte is taken only while `byte_valid` is high. A `sof` taken in the middle of an address discards the partial address and starts a new one.
- R11: After reset, `dec_valid`, `accept`, `filt_fail`, `is_mcast` and `is_bcast` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Marks the byte on `byte_data` as address byte 0 (taken only with `byte_valid`) |
| byte_valid | input | 1 | `byte_data` carries a byte this cycle |
| byte_data | input | 8 | Received byte |
| sta_hi | input | 16 | Station address bytes 5 and 4 |
| sta_lo | input | 32 | Station address bytes 3 to 0 |
| hash_hi | input | 32 | Hash bins 63 to 32 |
| hash_lo | input | 32 | Hash bins 31 to 0 |
| ctrl | input | 32 | Mode bits: 11 no-broadcast, 13 hash, 15 hash-only, 17 inverse, 18 promiscuous, 19 all-multicast |
| dec_valid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame accepted |
| is_mcast | output | 1 | Accepted frame is multicast |
| is_bcast | output | 1 | Accepted frame is broadcast |
| filt_fail | output | 1 | Frame rejected by the filter |

## Verification
The case where two functions share a cycle is a new frame starting while the previous decision is still on the outputs. The bench places the `sof` of the next address in the very cycle that `dec_valid` is high for the previous one. It then checks that the first decision is reported unchanged and that the second frame is judged from a clean CRC and clean match state, with its own single pulse six bytes later. A related overlap is a `sof` arriving mid-address, which must restart the filter instead of mixing the two partial addresses.

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sof,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  input  logic [15:0] sta_hi,
  input  logic [31:0] sta_lo,
  input  logic [31:0] hash_hi,
  input  logic [31:0] hash_lo,
  input  logic [31:0] ctrl,
  output logic        dec_valid,
  output logic        accept,
  output logic        is_mcast,
  output logic        is_bcast,
  output logic        filt_fail
);
  localparam int NBYTES = 6;
  localparam int CW = $clog2(NBYTES + 1);

  localparam int B_NOBC  = 11;
  localparam int B_HASH  = 13;
  localparam int B_HONLY = 15;
  localparam int B_INV   = 17;
  localparam int B_PROM  = 18;
  localparam int B_ALLMC = 19;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  logic [CW-1:0] cnt;
  logic [31:0]   crc;
  logic          eq_q, ff_q, mc_q;

  wire [CW-1:0] idx  = sof ? '0 : cnt;
  wire          take = byte_valid && (sof || cnt < CW'(NBYTES));
  wire          last = take && (idx == CW'(NBYTES - 1));

  wire [63:0] sta64 = {16'h0, sta_hi, sta_lo};
  wire [63:0] hash  = {hash_hi, hash_lo};
  wire [7:0]  sta_b = sta64[{idx, 3'b000} +: 8];

  wire [31:0] crc_n = crc_step(sof ? '1 : crc, byte_data);
  wire        eq_n  = (sof ? 1'b1 : eq_q) && (byte_data == sta_b);
  wire        ff_n  = (sof ? 1'b1 : ff_q) && (byte_data == 8'hFF);
  wire        mc_n  = (idx == '0) ? byte_data[0] : mc_q;

  wire       bc_frame = ff_n;
  wire       mc_frame = mc_n && !ff_n;
  wire       hhit     = hash[crc_n[31:26]];
  logic      pass_raw, pass;

  always_comb begin
    if (bc_frame)
      pass_raw = !ctrl[B_NOBC];
    else if (mc_frame)
      pass_raw = ctrl[B_ALLMC] || (ctrl[B_HASH] && hhit);
    else if (ctrl[B_HASH] && ctrl[B_HONLY])
      pass_raw = hhit;
    else
      pass_raw = eq_n;
    pass = ctrl[B_PROM] || (pass_raw ^ ctrl[B_INV]);
  end

  logic unused_ctrl;
  assign unused_ctrl = ^{ctrl[31:20], ctrl[16], ctrl[14], ctrl[12], ctrl[10:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      crc       <= '1;
      eq_q      <= 1'b0;
      ff_q      <= 1'b0;
      mc_q      <= 1'b0;
      dec_valid <= 1'b0;
      accept    <= 1'b0;
      is_mcast  <= 1'b0;
      is_bcast  <= 1'b0;
      filt_fail <= 1'b0;
    end else begin
      dec_valid <= last;
      if (take) begin
        cnt  <= idx + CW'(1);
        crc  <= crc_n;
        eq_q <= eq_n;
        ff_q <= ff_n;
        mc_q <= mc_n;
      end
      if (last) begin
        accept    <= pass;
        filt_fail <= !pass;
        is_mcast  <= pass && mc_frame;
        is_bcast  <= pass && bc_frame;
      end
    end
  end
endmodule

// File: rtl/rx_addr_filter_chk.sv
`timescale 1ns/1ps
module rx_addr_filter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        byte_valid,
  input logic [31:0] ctrl,
  input logic        dec_valid,
  input logic        accept,
  input logic        is_mcast,
  input logic        is_bcast,
  input logic        filt_fail
);
  assert_prom_accepts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && $past(ctrl[18]) |-> accept);

  assert_flags_need_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mcast || is_bcast) |-> accept && !filt_fail);

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_mcast && is_bcast));

  assert_bcast_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && is_bcast |-> !$past(ctrl[11]) || $past(ctrl[18]));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> $stable(accept) && $stable(filt_fail) && $stable(is_mcast) && $stable(is_bcast));

  assert_byte_before_dec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(byte_valid));
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (.*);

// File: tb/rx_addr_filter_test.sv
`timescale 1ns/1ps
module rx_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sof = 1'b0, byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [15:0] sta_hi;
  logic [31:0] sta_lo, hash_hi = '0, hash_lo = '0, ctrl = '0;
  logic        dec_valid, accept, is_mcast, is_bcast, filt_fail;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  localparam logic [47:0] STA   = 48'h021122334455;
  localparam logic [47:0] OTHER = 48'h0A0B0C0D0E0F;
  localparam logic [47:0] MCA   = 48'h01005E000001;
  localparam logic [47:0] BCA   = 48'hFFFFFFFFFFFF;

  assign sta_lo = {STA[23:16], STA[31:24], STA[39:32], STA[47:40]};
  assign sta_hi = {STA[7:0], STA[15:8]};

  rx_addr_filter uut (.*);

  typedef struct packed {
    logic [31:0] c;
    logic [47:0] d;
    logic        hs;
    logic        acc, mc, bc;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{32'h00000, STA,                0, 1, 0, 0},
    '{32'h00000, 48'h021122334456,   0, 0, 0, 0},
    '{32'h00000, BCA,                0, 1, 0, 1},
    '{32'h00800, BCA,                0, 0, 0, 0},
    '{32'h00000, MCA,                0, 0, 0, 0},
    '{32'h80000, MCA,                0, 1, 1, 0},
    '{32'h02000, MCA,                1, 1, 1, 0},
    '{32'h02000, MCA,                0, 0, 0, 0},
    '{32'h40000, OTHER,              0, 1, 0, 0},
    '{32'h20000, STA,                0, 0, 0, 0},
    '{32'h20000, OTHER,              0, 1, 0, 0},
    '{32'h60000, STA,                0, 1, 0, 0},
    '{32'h0A000, STA,                0, 0, 0, 0},
    '{32'h0A000, OTHER,              1, 1, 0, 0},
    '{32'h02000, STA,                0, 1, 0, 0},
    '{32'h80800, BCA,                0, 0, 0, 0},
    '{32'h02000, OTHER,              1, 0, 0, 0}
  };

  function automatic logic [5:0] bin_of(input logic [47:0] d);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = d[47 - 8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        if (r[0] != b[j]) r = (r >> 1) ^ 32'hEDB88320;
        else              r = r >> 1;
      end
    end
    return r[31:26];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [3:0] got;
  int         pulses;

  task automatic send(input logic [47:0] d, input int n);
    pulses = 0;
    got = '0;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (dec_valid) begin
        pulses++;
        got = {accept, filt_fail, is_mcast, is_bcast};
        if (i != 6) check("R9 pulse cycle", i, 6);
      end
      if (i < n) begin
        sof = (i == 0);
        byte_valid = 1'b1;
        byte_data = d[47 - 8*(i % 6) -: 8];
      end else begin
        sof = 1'b0;
        byte_valid = 1'b0;
      end
    end
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {dec_valid, accept, filt_fail, is_mcast, is_bcast}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after release", {dec_valid, accept, filt_fail, is_mcast, is_bcast}, 0);

    for (int v = 0; v < NV; v++) begin
      ctrl = VECS[v].c;
      {hash_hi, hash_lo} = VECS[v].hs ? (64'd1 << bin_of(VECS[v].d)) : 64'd0;
      send(VECS[v].d, 6);
      check($sformatf("R1-table vector %0d pulses (R9)", v), pulses, 1);
      check($sformatf("vector %0d R8 R3 R2 R5 R6 R7", v), got,
            {VECS[v].acc, !VECS[v].acc, VECS[v].mc, VECS[v].bc});
    end

    for (int k = 0; k < 16; k++) begin
      logic [47:0] d = MCA + 48'(k * 7);
      logic [5:0]  b = bin_of(d);
      ctrl = 32'h02000;
      {hash_hi, hash_lo} = 64'd1 << b;
      send(d, 6);
      check($sformatf("R4 bin %0d hit", b), got[3], 1);
      {hash_hi, hash_lo} = ~(64'd1 << b);
      send(d, 6);
      check($sformatf("R4 bin %0d miss", b), got[3], 0);
    end

    ctrl = 32'h0;
    {hash_hi, hash_lo} = '0;
    send(STA, 9);
    check("R10 trailing bytes single pulse", pulses, 1);
    check("R10 trailing bytes accept", got[3], 1);
    repeat (2) @(negedge clk);
    check("R9 outputs hold", {dec_valid, accept, filt_fail}, 3'b010);

    send(OTHER, 3);
    check("R10 partial no pulse", pulses, 0);
    send(STA, 6);
    check("R10 restart accept", got, 4'b1000);

    pulses = 0;
    for (int i = 0; i <= 12; i++) begin
      @(negedge clk);
      if (dec_valid) begin
        pulses++;
        if (i == 6)  check("R9 back-to-back first", {accept, filt_fail}, 2'b10);
        else if (i == 12) check("R9 back-to-back second", {accept, filt_fail}, 2'b01);
        else check("R9 back-to-back pulse cycle", i, 6);
      end
      if (i < 12) begin
        sof = (i % 6 == 0);
        byte_valid = 1'b1;
        byte_data = (i < 6) ? STA[47 - 8*i -: 8] : OTHER[47 - 8*(i-6) -: 8];
      end else begin
        sof = 1'b0;
        byte_valid = 1'b0;
      end
    end
    check("R9 back-to-back pulses", pulses, 2);

    pulses = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (dec_valid) pulses++;
      sof = (i == 0);
      byte_valid = (i % 2 == 0);
      byte_data = STA[47 - 8*(i/2) -: 8];
    end
    @(negedge clk);
    if (dec_valid) pulses++;
    byte_valid = 1'b0;
    check("R10 gapped bytes pulses", pulses, 1);
    check("R10 gapped bytes accept", accept, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule